// File: doc/BRIEF.md
# Token-Ring Hit Readout Controller

This block sits in every chip of a chain of detector readout chips and decides when that chip may drive its hit frames onto the shared output. Each chip keeps up to 32 hit frames in a local first-in first-out buffer. A mode pin makes exactly one chip of the chain the master. The master watches a chain-wide data-available line, which is the wired OR of every chip's buffer-not-empty flag. When that line is high and no round is in progress, the master opens a readout round by taking the token itself.

A chip that holds the token sends at most a configured burst of frames. It then hands the token to the next chip with a one-cycle pulse. A chip whose buffer is empty, or whose burst length is zero, hands the token on at once. The last chip's token output is wired back to the master. A round ends when the token returns to the master, and only then may the master open a new one.

Both data interfaces are valid/ready streams. On the write side, `wr_ready` is low while the buffer is full. A frame offered while `wr_ready` is low is dropped and sets a sticky overflow flag. On the read side, `out_valid` is high only while a frame is on `out_frame`. A frame is consumed only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the same frame stays on the output.

Top module: `chain_readout_ctrl`

## Requirements
- R1: The buffer accepts frames while it holds fewer than 32. With 32 held, `wr_ready` is low. Frames leave in the order they were accepted.
- R2: A frame offered while `wr_ready` is low is not stored. It sets `overflow`, which stays high until reset.
- R3: `buf_nonempty` is high exactly while the buffer holds at least one frame.
- R4: In master mode (`is_master`=1), a round opens on the clock edge where `chain_avail_in` is high and no round is in progress. The master then behaves as a token holder from the next cycle. No new round opens until a `token_in` pulse has been seen.
- R5: In slave mode, `chain_avail_in` has no effect, and the chip acts only on a `token_in` pulse. In master mode, `token_in` only ends the round and never makes the master send.
- R6: A token holder with H frames buffered and burst length B>0 sends min(H,B) frames in buffer order. Counting from the first cycle after the token edge as cycle 0, the frames appear in cycles 0 to min(H,B)-1 when `out_ready` stays high, and `token_out` pulses in cycle min(H,B)+1.
- R7: A token holder with an empty buffer, or with `burst_len`=0, pulses `token_out` in cycle 0 and sends nothing.
- R8: `token_out` is never high for two consecutive cycles.
- R9: `out_valid` is high only while a frame is driven. While `out_ready` is low, `out_valid` stays high and `out_frame` keeps its value.
- R10: Frames pass through unchanged, 23 bits wide: bit 22 is the timestamp-valid flag, bits 21:7 are the 15-bit timestamp, and bits 6:0 are the channel address.
- R11: After reset the buffer is empty, `wr_ready`=1, and `out_valid`, `token_out`, `buf_nonempty` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 = this chip opens rounds |
| burst_len | input | 6 | Maximum frames sent per token visit |
| wr_valid | input | 1 | Hit frame offered to the buffer |
| wr_ready | output | 1 | Buffer can accept a frame |
| wr_frame | input | 23 | Hit frame {ts_valid, timestamp, channel} |
| overflow | output | 1 | Sticky: a frame was dropped on a full buffer |
| buf_nonempty | output | 1 | This chip holds data (for the wired OR) |
| chain_avail_in | input | 1 | Wired OR of all chips' buffer-not-empty flags |
| token_in | input | 1 | Token pulse from the previous chip |
| token_out | output | 1 | Token pulse to the next chip |
| out_valid | output | 1 | A frame is on `out_frame` |
| out_ready | input | 1 | Downstream accepts the frame |
| out_frame | output | 23 | Frame being sent |

## Verification
The bench builds the block with its default parameters: a buffer depth of 32 and a 6-bit burst length. With these values, a full buffer and a burst of 32 can both be reached within one run. Table rows cover the case where the buffer runs out before the burst ends, the case where the burst ends first, an exact match, and a zero burst. Directed tests cover overflow on a full buffer, a stalled output, and the master's round lock across an open round.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  localparam int TS_W    = 15;
  localparam int CH_W    = 7;
  localparam int FRAME_W = 1 + TS_W + CH_W;

  typedef struct packed {
    logic            ts_ok;
    logic [TS_W-1:0] stamp;
    logic [CH_W-1:0] chan;
  } hit_frame_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SEND = 1'b1
  } seq_state_t;
endpackage

// File: rtl/hit_buffer.sv
module hit_buffer #(
  parameter int DEPTH = 32,
  parameter int W     = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign full       = (cnt == CW'(DEPTH));
  assign empty      = (cnt == '0);
  assign push_ready = !full;
  assign do_push    = push_valid && !full;
  assign do_pop     = pop && !empty;
  assign head       = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push_valid && full) overflow <= 1'b1;
    end
  end

  // R1: occupancy never exceeds depth
  assert_depth_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R2: overflow is sticky
  assert_overflow_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R2: an offer on a full buffer leaves occupancy unchanged when nothing pops
  assert_full_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !pop) |=> full);
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
  import chain_rd_pkg::*;
#(
  parameter int BURST_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant,
  input  logic [BURST_W-1:0] burst_len,
  input  logic               buf_empty,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               pop,
  output logic               token_out,
  output logic               idle
);
  seq_state_t         state;
  logic [BURST_W-1:0] sent;
  logic               quota_done;

  assign quota_done = (sent >= burst_len);
  assign out_valid  = (state == SEQ_SEND) && !buf_empty && !quota_done;
  assign pop        = out_valid && out_ready;
  assign idle       = (state == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      sent      <= '0;
      token_out <= 1'b0;
    end else begin
      token_out <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (grant) begin
            if (buf_empty || burst_len == '0) begin
              token_out <= 1'b1;
            end else begin
              state <= SEQ_SEND;
              sent  <= '0;
            end
          end
        end
        SEQ_SEND: begin
          if (pop) sent <= sent + 1'b1;
          if (buf_empty || quota_done) begin
            state     <= SEQ_IDLE;
            token_out <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R8: token pulse lasts a single cycle
  assert_token_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> !token_out);
  // R9: a stalled frame stays valid
  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  // R6: no frame is driven while the token is being handed on
  assert_no_send_on_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |-> !out_valid);
endmodule

// File: rtl/round_master.sv
module round_master (
  input  logic clk,
  input  logic rst_n,
  input  logic is_master,
  input  logic chain_avail,
  input  logic token_in,
  output logic grant
);
  logic busy, start;

  assign start = is_master && chain_avail && !busy;
  assign grant = is_master ? start : token_in;

  always_ff @(posedge clk) begin
    if (!rst_n)        busy <= 1'b0;
    else if (start)    busy <= 1'b1;
    else if (token_in) busy <= 1'b0;
  end

  // R5: a slave never opens a round
  assert_slave_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !start);
  // R4: two rounds never open on consecutive edges
  assert_single_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

// File: rtl/chain_readout_ctrl.sv
module chain_readout_ctrl
  import chain_rd_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int BURST_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_master,
  input  logic [BURST_W-1:0] burst_len,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [FRAME_W-1:0] wr_frame,
  output logic               overflow,
  output logic               buf_nonempty,
  input  logic               chain_avail_in,
  input  logic               token_in,
  output logic               token_out,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FRAME_W-1:0] out_frame
);
  logic               empty, pop, grant, seq_idle;
  logic [FRAME_W-1:0] head;

  hit_buffer #(.DEPTH(DEPTH), .W(FRAME_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (wr_valid),
    .push_ready (wr_ready),
    .push_data  (wr_frame),
    .pop        (pop),
    .head       (head),
    .empty      (empty),
    .overflow   (overflow)
  );

  round_master u_round (
    .clk         (clk),
    .rst_n       (rst_n),
    .is_master   (is_master),
    .chain_avail (chain_avail_in),
    .token_in    (token_in),
    .grant       (grant)
  );

  burst_sequencer #(.BURST_W(BURST_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant && seq_idle),
    .burst_len (burst_len),
    .buf_empty (empty),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .pop       (pop),
    .token_out (token_out),
    .idle      (seq_idle)
  );

  assign buf_nonempty = !empty;
  assign out_frame    = out_valid ? head : '0;

  // R9: frame held under back-pressure
  assert_frame_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_frame));
  // R3: nothing is sent from an empty buffer
  assert_valid_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> buf_nonempty);
endmodule

// File: tb/chain_readout_ctrl_test.sv
module chain_readout_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        is_master = 0;
  logic [5:0]  burst_len = 0;
  logic        wr_valid = 0;
  logic        wr_ready;
  logic [22:0] wr_frame = 0;
  logic        overflow, buf_nonempty;
  logic        chain_avail_in = 0;
  logic        token_in = 0;
  logic        token_out, out_valid;
  logic        out_ready = 1;
  logic [22:0] out_frame;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  chain_readout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .burst_len(burst_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_frame(wr_frame),
    .overflow(overflow), .buf_nonempty(buf_nonempty),
    .chain_avail_in(chain_avail_in), .token_in(token_in), .token_out(token_out),
    .out_valid(out_valid), .out_ready(out_ready), .out_frame(out_frame)
  );

  localparam int NROW = 6;
  localparam int HELD  [NROW] = '{0, 3, 2, 5, 4, 32};
  localparam int BURST [NROW] = '{4, 2, 5, 5, 0, 32};

  // R10 layout: {ts_valid[22], timestamp[21:7], channel[6:0]}
  function automatic logic [22:0] mk(input int i);
    logic [14:0] ts;
    logic [6:0]  ch;
    ts = 15'(i * 37 + 5);
    ch = 7'(i * 3 + 1);
    return {1'(i % 2), ts, ch};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_valid = 0; token_in = 0; chain_avail_in = 0; out_ready = 1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_frame = mk(i);
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  // Collect from the negedge right after the token edge (cycle 0).
  task automatic collect(input int limit, input int exp_frames, input int exp_tok,
                         input string tag);
    int got = 0, tok_at = -1, pulses = 0, bad = 0;
    for (int c = 0; c < limit; c++) begin
      if (out_valid && out_ready) begin
        if (out_frame !== mk(got)) bad++;
        if (c != got) bad++;
        got++;
      end
      if (token_out) begin
        pulses++;
        if (tok_at < 0) tok_at = c;
      end
      @(negedge clk);
    end
    chk(got == exp_frames, {tag, " frame count"}, got, exp_frames);
    chk(bad == 0, {tag, " frame order/content/timing"}, bad, 0);
    chk(tok_at == exp_tok, {tag, " token_out cycle"}, tok_at, exp_tok);
    chk(pulses == 1, {tag, " token pulse count R8"}, pulses, 1);
  endtask

  task automatic pulse_token();
    token_in = 1;
    @(negedge clk);
    token_in = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset();
    chk(wr_ready == 1, "R11 wr_ready", wr_ready, 1);
    chk(buf_nonempty == 0, "R11 buf_nonempty", buf_nonempty, 0);
    chk(out_valid == 0, "R11 out_valid", out_valid, 0);
    chk(token_out == 0, "R11 token_out", token_out, 0);
    chk(overflow == 0, "R11 overflow", overflow, 0);

    // Table: slave bursts (R6, R7, R10)
    for (int r = 0; r < NROW; r++) begin
      int n, t;
      do_reset();
      is_master = 0;
      burst_len = 6'(BURST[r]);
      push_n(HELD[r]);
      chk(buf_nonempty == (HELD[r] > 0), "R3 nonempty after pushes", buf_nonempty, HELD[r] > 0);
      n = (HELD[r] < BURST[r]) ? HELD[r] : BURST[r];
      t = (n == 0) ? 0 : n + 1;
      pulse_token();
      collect(40, n, t, (n == 0) ? "R7 table" : "R6 table");
      chk(buf_nonempty == (HELD[r] > n), "R3 nonempty after burst", buf_nonempty, HELD[r] > n);
    end

    // R1/R2 full buffer and overflow
    do_reset();
    push_n(31);
    chk(wr_ready == 1, "R1 ready at 31", wr_ready, 1);
    wr_valid = 1; wr_frame = mk(31);
    @(negedge clk);
    chk(wr_ready == 0, "R1 not ready at 32", wr_ready, 0);
    chk(overflow == 0, "R2 no overflow before drop", overflow, 0);
    wr_frame = 23'h7ABCDE;
    @(negedge clk);
    wr_valid = 0;
    chk(overflow == 1, "R2 overflow set", overflow, 1);
    burst_len = 6'd40;
    pulse_token();
    collect(40, 32, 33, "R1 drain full");
    chk(overflow == 1, "R2 overflow sticky", overflow, 1);
    chk(buf_nonempty == 0, "R2 dropped frame not stored", buf_nonempty, 0);
    do_reset();
    chk(overflow == 0, "R2 overflow cleared by reset", overflow, 0);

    // R9 back-pressure
    do_reset();
    burst_len = 6'd2;
    push_n(2);
    out_ready = 0;
    pulse_token();
    for (int c = 0; c < 3; c++) begin
      chk(out_valid == 1, "R9 valid held", out_valid, 1);
      chk(out_frame == mk(0), "R9 frame held", out_frame, mk(0));
      chk(token_out == 0, "R9 no token while stalled", token_out, 0);
      @(negedge clk);
    end
    out_ready = 1;
    collect(10, 2, 3, "R9 after release");

    // R5 slave ignores chain_avail_in
    do_reset();
    is_master = 0; burst_len = 6'd4;
    push_n(1);
    chain_avail_in = 1;
    begin
      int seen = 0;
      for (int c = 0; c < 5; c++) begin
        if (out_valid || token_out) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R5 slave ignores avail", seen, 0);
    end
    chain_avail_in = 0;

    // R4 master round
    do_reset();
    is_master = 1; burst_len = 6'd4;
    push_n(2);
    chk(out_valid == 0, "R4 no round without avail", out_valid, 0);
    chain_avail_in = 1;
    @(negedge clk);
    collect(6, 2, 3, "R4 master opens round");
    push_n(1);
    begin
      int seen = 0;
      for (int c = 0; c < 5; c++) begin
        if (out_valid || token_out) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R4 no new round while open", seen, 0);
    end
    chain_avail_in = 0;
    pulse_token();
    begin
      int seen = 0;
      for (int c = 0; c < 3; c++) begin
        if (out_valid || token_out) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R5 master token_in does not send", seen, 0);
    end
    chain_avail_in = 1;
    @(negedge clk);
    chain_avail_in = 0;
    chk(out_valid == 1, "R4 new round after return", out_valid, 1);
    chk(out_frame == mk(0), "R4 new round frame", out_frame, mk(0));

    // R7 master with empty own buffer passes at once
    do_reset();
    is_master = 1; burst_len = 6'd4;
    chain_avail_in = 1;
    @(negedge clk);
    chain_avail_in = 0;
    chk(token_out == 1, "R7 master empty passes token", token_out, 1);
    @(negedge clk);
    chk(token_out == 0, "R8 master pulse ends", token_out, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule